// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a synchronous user request port to an external asynchronous static RAM. The RAM has a shared bidirectional 16-bit data bus and three active-low strobes: chip select, output enable and write enable. The user side offers one command per cycle. A command is a read or a write, with an address and write data. The controller turns each command into the strobe sequence the memory needs. Read data comes back with a one-cycle valid pulse.

The bidirectional bus is split at the block edge into an output word, a drive enable and an input word, and the pad cell joins them outside the block. Writes run as a fixed sequence of phases that keeps the address and data steady around the write strobe. When a write directly follows another write, the sequence loses its first phase. Reads run back to back at one per cycle. The address comes straight from a register, and the bus is captured on the next edge. A read can either take its address from the command or step the previous address forward by a fixed amount, which gives streaming bursts.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held, chip select, output enable and write enable are all high (inactive), the bus drive enable is low, and busy and read-valid are low.
- R2: A write accepted from idle or after a read occupies four cycles, starting the cycle after acceptance. Phase one has all strobes high and the drive off. Phase two has chip select low and the drive on, with write enable high. Phase three pulls write enable low. Phase four raises write enable again with the drive still on.
- R3: A write accepted during the fourth phase of a preceding write skips phase one. It starts directly with the drive phase and takes three cycles.
- R4: In phases two to four, the address equals the command address and the output word equals the command data, and neither changes across the fall or rise of write enable.
- R5: All strobes are active-low. Output enable is low only in the cycle a read is presented. It is never low together with write enable, and chip select is low whenever either of them is.
- R6: The drive enable is high only in write phases two to four. The bus is never driven while the memory's outputs are enabled.
- R7: An accepted read presents its address the next cycle with chip select and output enable low. The bus is sampled at the end of that cycle, and the word appears on the read-data output in the cycle after. Reads may be accepted on every cycle.
- R8: A read with the increment flag set ignores the command address and uses the previously loaded address plus 4 (ADDR_STEP).
- R9: Busy is high from the cycle after a write is accepted through its write-strobe phase, and low in the final phase. Commands that arrive while busy is high have no effect.
- R10: Read-valid is high for exactly one cycle per accepted read, and only in the cycle after that read's output-enable cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_incr | input | 1 | Read uses previous address plus step |
| req_addr | input | ADDR_W | Command address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Write in progress; commands ignored |
| rd_valid | output | 1 | Read word valid pulse |
| rd_data | output | DATA_W | Captured read word |
| sram_addr | output | ADDR_W | Memory address |
| sram_dq_o | output | DATA_W | Data to drive onto the bus |
| sram_dq_oe | output | 1 | Bus drive enable for the pad |
| sram_dq_i | input | DATA_W | Data sampled from the bus |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |

## Verification
The hardest situation to reach is a write command that lands in exactly the final phase of the previous write. Only that timing selects the shortened three-cycle sequence. A read arriving in the same slot, or a command arriving while busy is high, must not disturb anything. The stimulus waits on the busy port and fires the next command in the first cycle busy is low. It also fires commands on purpose while busy is high. A long random run with a small address set then mixes reads, increment bursts and writes, so that writes chain, get refused, and are read back from the same locations.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OEOFF,
        PH_SETUP,
        PH_STROBE,
        PH_RELEASE
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } strobe_t;

    localparam strobe_t STB_QUIET = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
    localparam strobe_t STB_DRIVE = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b1};
    localparam strobe_t STB_WRITE = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b1};
    localparam strobe_t STB_READ  = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, dq_oe: 1'b0};

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    req_write,
    output logic    busy,
    output logic    acc_rd,
    output logic    acc_wr,
    output strobe_t stb,
    output logic    rd_issue
);

    typedef struct packed {
        phase_e  ph;
        strobe_t stb;
        logic    rd;
    } seq_s;

    seq_s seq_d, seq_q;
    logic accept;

    always_comb begin
        busy   = (seq_q.ph == PH_OEOFF) || (seq_q.ph == PH_SETUP) || (seq_q.ph == PH_STROBE);
        accept = req_valid && !busy;
        acc_wr = accept && req_write;
        acc_rd = accept && !req_write;

        seq_d     = seq_q;
        seq_d.ph  = PH_IDLE;
        seq_d.stb = STB_QUIET;
        seq_d.rd  = 1'b0;

        unique case (seq_q.ph)
            PH_OEOFF: begin
                seq_d.ph  = PH_SETUP;
                seq_d.stb = STB_DRIVE;
            end
            PH_SETUP: begin
                seq_d.ph  = PH_STROBE;
                seq_d.stb = STB_WRITE;
            end
            PH_STROBE: begin
                seq_d.ph  = PH_RELEASE;
                seq_d.stb = STB_DRIVE;
            end
            default: begin
                if (acc_wr) begin
                    if (seq_q.ph == PH_RELEASE) begin
                        seq_d.ph  = PH_SETUP;
                        seq_d.stb = STB_DRIVE;
                    end else begin
                        seq_d.ph  = PH_OEOFF;
                        seq_d.stb = STB_QUIET;
                    end
                end else if (acc_rd) begin
                    seq_d.ph  = PH_IDLE;
                    seq_d.stb = STB_READ;
                    seq_d.rd  = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{ph: PH_IDLE, stb: STB_QUIET, rd: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign stb      = seq_q.stb;
    assign rd_issue = seq_q.rd;

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!stb.oe_n && !stb.we_n));

    // R6
    drive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb.dq_oe |-> stb.oe_n);

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> !rd_issue);

    // R3
    chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph == PH_RELEASE && acc_wr) |=> (stb.dq_oe && stb.we_n && !stb.ce_n));

endmodule

// File: rtl/sram_ctl_addr.sv
module sram_ctl_addr #(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int ADDR_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic              req_incr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ADDR_STEP);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } hold_s;

    hold_s hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (acc_wr) begin
            hold_d.addr  = req_addr;
            hold_d.wdata = req_wdata;
        end else if (acc_rd) begin
            hold_d.addr = req_incr ? (hold_q.addr + STEP) : req_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign addr_o  = hold_q.addr;
    assign wdata_o = hold_q.wdata;

    // R8
    incr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && req_incr) |=> (addr_o == $past(addr_o) + STEP));

endmodule

// File: rtl/sram_ctl_rdcap.sv
module sram_ctl_rdcap #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issue,
    input  logic [DATA_W-1:0] dq_i,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } cap_s;

    cap_s cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = rd_issue;
        if (rd_issue) begin
            cap_d.data = dq_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rd_valid = cap_q.valid;
    assign rd_data  = cap_q.data;

    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_issue |=> $stable(rd_data));

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int ADDR_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_incr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_i,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n
);

    logic    acc_rd;
    logic    acc_wr;
    logic    rd_issue;
    strobe_t stb;

    sram_ctl_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .busy     (busy),
        .acc_rd   (acc_rd),
        .acc_wr   (acc_wr),
        .stb      (stb),
        .rd_issue (rd_issue)
    );

    sram_ctl_addr #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .ADDR_STEP(ADDR_STEP)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_rd   (acc_rd),
        .acc_wr   (acc_wr),
        .req_incr (req_incr),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .addr_o   (sram_addr),
        .wdata_o  (sram_dq_o)
    );

    sram_ctl_rdcap #(
        .DATA_W(DATA_W)
    ) u_rdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_issue(rd_issue),
        .dq_i    (sram_dq_i),
        .rd_valid(rd_valid),
        .rd_data (rd_data)
    );

    assign sram_ce_n  = stb.ce_n;
    assign sram_oe_n  = stb.oe_n;
    assign sram_we_n  = stb.we_n;
    assign sram_dq_oe = stb.dq_oe;

    // R4
    write_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> ($past(sram_dq_oe) && $stable(sram_addr) && $stable(sram_dq_o)));

    // R4
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (sram_dq_oe && $stable(sram_addr) && $stable(sram_dq_o)));

    // R10
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!sram_oe_n));

    // R5
    ce_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n || !sram_oe_n) |-> !sram_ce_n);

endmodule

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb;

    localparam int AW   = 18;
    localparam int DW   = 16;
    localparam int STEP = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_write;
    logic          req_incr;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          busy;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] sram_dq_o;
    logic          sram_dq_oe;
    logic [DW-1:0] sram_dq_i;
    logic          sram_ce_n;
    logic          sram_oe_n;
    logic          sram_we_n;

    always #5 clk = ~clk;

    sram_ctl #(.ADDR_W(AW), .DATA_W(DW), .ADDR_STEP(STEP)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_incr(req_incr), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .sram_addr(sram_addr), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
        .sram_dq_i(sram_dq_i), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    function automatic logic [DW-1:0] dflt(input logic [AW-1:0] a);
        return a[DW-1:0] ^ 16'hA5C3;
    endfunction

    // ---------------- memory model on the pins ----------------
    logic [DW-1:0] mem [int];
    int            mem_gen = 0;
    logic          sram_drv;

    assign sram_drv = (sram_ce_n === 1'b0) && (sram_oe_n === 1'b0) && (sram_we_n === 1'b1);

    always @(sram_addr, sram_oe_n, sram_ce_n, sram_we_n, mem_gen) begin
        if (sram_drv)
            sram_dq_i = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : dflt(sram_addr);
        else
            sram_dq_i = 16'hFFFF;
    end

    always @(posedge sram_we_n) begin
        if (sram_ce_n === 1'b0 && sram_dq_oe === 1'b1) begin
            mem[int'(sram_addr)] = sram_dq_o;
            mem_gen = mem_gen + 1;
        end
    end

    // ---------------- reference model ----------------
    logic [3:0]    e_ctl  [int];
    string         e_tag  [int];
    bit            e_busy [int];
    logic [AW-1:0] e_addr [int];
    logic [DW-1:0] e_wd   [int];
    bit            e_rv   [int];
    logic [DW-1:0] e_rd   [int];
    string         e_rtag [int];
    logic [DW-1:0] ref_mem [int];
    int            last_rel  = -10;
    logic [AW-1:0] last_addr = '0;

    always @(posedge clk) begin : model
        int k;
        int s;
        logic [AW-1:0] a;
        string tg;
        if (!rst_n) begin
            cyc = 0;
        end else begin
            cyc = cyc + 1;
            k = cyc;
            if (req_valid && !(e_busy.exists(k-1) && e_busy[k-1])) begin
                if (req_write) begin
                    if (last_rel == k-1) begin
                        s  = k;
                        tg = "R3";
                    end else begin
                        s  = k + 1;
                        tg = "R2";
                        e_ctl[k] = 4'b1110; e_tag[k] = tg; e_busy[k] = 1;
                    end
                    e_ctl[s]   = 4'b0111; e_busy[s]   = 1;
                    e_ctl[s+1] = 4'b0101; e_busy[s+1] = 1;
                    e_ctl[s+2] = 4'b0111; e_busy[s+2] = 0;
                    for (int j = 0; j < 3; j++) begin
                        e_tag[s+j]  = tg;
                        e_addr[s+j] = req_addr;
                        e_wd[s+j]   = req_wdata;
                    end
                    last_rel  = s + 2;
                    last_addr = req_addr;
                    ref_mem[int'(req_addr)] = req_wdata;
                end else begin
                    a  = req_incr ? last_addr + AW'(STEP) : req_addr;
                    tg = req_incr ? "R8" : "R7";
                    last_addr  = a;
                    e_ctl[k]   = 4'b0010;
                    e_tag[k]   = tg;
                    e_addr[k]  = a;
                    e_rv[k+1]  = 1;
                    e_rd[k+1]  = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : dflt(a);
                    e_rtag[k+1] = tg;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin : compare
        logic [3:0] ex;
        string tg;
        if (rst_n === 1'b1 && !done) begin
            ex = e_ctl.exists(cyc) ? e_ctl[cyc] : 4'b1110;
            tg = e_tag.exists(cyc) ? e_tag[cyc] : "R5";
            chk({sram_ce_n, sram_oe_n, sram_we_n} === ex[3:1], tg,
                {29'd0, sram_ce_n, sram_oe_n, sram_we_n}, {29'd0, ex[3:1]});
            chk(sram_dq_oe === ex[0], "R6 drive", {31'd0, sram_dq_oe}, {31'd0, ex[0]});
            chk(!(sram_dq_oe && sram_drv), "R6 contention", {31'd0, sram_dq_oe}, 32'd0);
            chk(busy === (e_busy.exists(cyc) && e_busy[cyc]), "R9 busy",
                {31'd0, busy}, {31'd0, e_busy.exists(cyc) && e_busy[cyc]});
            chk(rd_valid === (e_rv.exists(cyc) && e_rv[cyc]), "R10 rd_valid",
                {31'd0, rd_valid}, {31'd0, e_rv.exists(cyc) && e_rv[cyc]});
            if (e_rv.exists(cyc))
                chk(rd_data === e_rd[cyc], e_rtag[cyc], {16'd0, rd_data}, {16'd0, e_rd[cyc]});
            if (e_addr.exists(cyc))
                chk(sram_addr === e_addr[cyc], "R4 addr", {14'd0, sram_addr}, {14'd0, e_addr[cyc]});
            if (e_wd.exists(cyc))
                chk(sram_dq_o === e_wd[cyc], "R4 data", {16'd0, sram_dq_o}, {16'd0, e_wd[cyc]});
        end
    end

    // ---------------- stimulus ----------------
    task automatic drive(input bit w, input bit inc, input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = 1'b1; req_write = w; req_incr = inc; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic issue(input bit w, input bit inc, input logic [AW-1:0] a, input logic [DW-1:0] d);
        while (busy) @(negedge clk);
        drive(w, inc, a, d);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_incr = 1'b0;
        req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sram_ce_n === 1'b1 && sram_oe_n === 1'b1 && sram_we_n === 1'b1, "R1 strobes",
            {29'd0, sram_ce_n, sram_oe_n, sram_we_n}, 32'd7);
        chk(sram_dq_oe === 1'b0, "R1 drive", {31'd0, sram_dq_oe}, 32'd0);
        chk(busy === 1'b0 && rd_valid === 1'b0, "R1 flags", {30'd0, busy, rd_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // single write from idle (R2), then read back (R7)
        issue(1, 0, 18'h00100, 16'h1234);
        issue(0, 0, 18'h00100, 16'h0);
        repeat (3) @(negedge clk);

        // back-to-back writes chain (R3)
        issue(1, 0, 18'h00200, 16'hAAAA);
        issue(1, 0, 18'h00204, 16'h5555);
        issue(1, 0, 18'h00208, 16'hC3C3);
        // read right in the release slot
        issue(0, 0, 18'h00204, 16'h0);

        // streaming reads every cycle, then increment burst (R7, R8)
        drive(0, 0, 18'h00200, 16'h0);
        drive(0, 1, 18'h00000, 16'h0);
        drive(0, 1, 18'h3FFFF, 16'h0);
        drive(0, 1, 18'h00000, 16'h0);
        drive(0, 0, 18'h3FFFC, 16'h0);
        drive(0, 1, 18'h00000, 16'h0);
        // write directly after a read (R2)
        drive(1, 0, 18'h00300, 16'hBEEF);
        // commands while busy are ignored (R9)
        drive(0, 0, 18'h00500, 16'h0);
        drive(1, 0, 18'h00504, 16'hDEAD);
        issue(0, 0, 18'h00300, 16'h0);
        repeat (4) @(negedge clk);

        // random mix over a small address set
        for (int i = 0; i < 1500; i++) begin
            req_valid = ($urandom_range(0, 3) != 0);
            req_write = ($urandom_range(0, 2) == 0);
            req_incr  = ($urandom_range(0, 3) == 0);
            req_addr  = AW'(18'h00400 + 4 * $urandom_range(0, 7));
            req_wdata = DW'($urandom);
            @(negedge clk);
        end
        req_valid = 1'b0;
        repeat (6) @(negedge clk);
        finish_run();
    end

endmodule